// File: doc/BRIEF.md
# Raster Position Timer

This block is a programmable position timer with two counting modes. In raster mode it follows a video beam: a 9-bit dot counter steps from 0 to 340 and then wraps. Each wrap advances a 9-bit line counter. The line counter wraps after line 261 or line 311, depending on the video standard chosen on the `fifty_hz` pin. In linear mode the same two fields join into one 18-bit free-running counter. The dot field is the low half and the line field is the high half. The count moves by one on every cycle in which the single-cycle `dot_en` strobe is high.

A host programs the block over a byte-wide write port. It can set the mode, the two compare enables and a 9-bit compare value for each axis, and it can restart the count. It reads the counts back as byte pairs over a read port with no latency. Reading the low byte of the dot count also freezes a snapshot of both counts. The other three bytes then come from that snapshot, so a value cannot tear across the two byte reads. When the count steps onto a position that matches every enabled compare, `timer_irq` is set. It stays high until the host clears it.

Top module: `raster_timer`

## Requirements
- R1: After synchronous reset, both counts are 0, the control and compare registers are 0 and `timer_irq` is low.
- R2: Any write to write address 1 (restart) forces both counts to 0 on that clock edge, whatever the data byte is, and it outranks a `dot_en` pulse in the same cycle.
- R3: With control bit 7 = 0 (raster mode), each `dot_en` pulse increments the dot count. From any value of 340 or above it wraps to 0.
- R4: In raster mode the line count increments when the dot count wraps. It wraps to 0 from line 261 or above when `fifty_hz` = 0, and from line 311 or above when `fifty_hz` = 1.
- R5: With control bit 7 = 1 (linear mode), {line, dot} behaves as one 18-bit counter that increments per `dot_en` pulse, carrying from dot 511 into the line field. `fifty_hz` has no effect.
- R6: Control bit 0 enables the dot compare and bit 1 enables the line compare (write address 0). A `dot_en` step onto a position whose enabled axes all equal their compare values sets `timer_irq` on that same edge. With neither enable set, `timer_irq` is never set.
- R7: `timer_irq` stays set until a write to address 6 with data bit 0 = 1. Such a write with bit 0 = 0 has no effect. A new event in the same cycle as a clear leaves the flag set.
- R8: Write addresses 2/3 hold the dot compare and 4/5 hold the line compare. The low byte gives bits 7:0, and only bit 0 of the high byte is kept, as bit 8; the other high-byte bits are ignored.
- R9: Read address 0 returns the live dot count bits 7:0. Read addresses 1, 2 and 3 return, from the snapshot, dot bit 8 (in bit 0), line bits 7:0 and line bit 8 (in bit 0), with all other bits 0.
- R10: The snapshot is loaded with both counts only on a read of address 0 and otherwise holds, so the high byte read later matches the low byte even while the count moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifty_hz | input | 1 | Video standard select: 1 gives 312 lines, 0 gives 262 lines |
| dot_en | input | 1 | Single-cycle count advance strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 8 | Write data byte |
| rd_en | input | 1 | Read strobe; on address 0 it loads the snapshot |
| rd_addr | input | 2 | Read register address |
| rd_data | output | 8 | Read data byte, combinational |
| timer_irq | output | 1 | Timer event flag |

## Verification
The assertions assume `rst` is held high from time zero until the first clock edges, so that each `$past` value comes from a defined register. They also assume that `fifty_hz` and the mode bit do not change in the middle of a step, so a wrap is always judged against the limit in force during that cycle. The stimulus changes every input only on the falling clock edge and changes `fifty_hz` and the control byte only while `dot_en` is low. Only the snapshot test keeps `dot_en` high across the reads, because it is meant to show that the count moves between the two byte reads.

// File: rtl/rtmr_pkg.sv
package rtmr_pkg;
    parameter int CNT_W   = 9;
    parameter int DATA_W  = 8;
    parameter int WADDR_W = 3;
    parameter int RADDR_W = 2;

    localparam int LIN_W    = 2 * CNT_W;
    localparam int HI_W     = CNT_W - DATA_W;
    localparam int MODE_BIT = 7;
    localparam int VEN_BIT  = 1;
    localparam int HEN_BIT  = 0;
    localparam int CLR_BIT  = 0;

    localparam logic [CNT_W-1:0] H_LAST    = CNT_W'(340);
    localparam logic [CNT_W-1:0] V_LAST_60 = CNT_W'(261);
    localparam logic [CNT_W-1:0] V_LAST_50 = CNT_W'(311);
    localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);

    typedef enum logic {
        MODE_RASTER = 1'b0,
        MODE_LINEAR = 1'b1
    } tmode_e;

    typedef enum logic [WADDR_W-1:0] {
        WA_CTRL    = WADDR_W'(0),
        WA_RESTART = WADDR_W'(1),
        WA_HCMP_LO = WADDR_W'(2),
        WA_HCMP_HI = WADDR_W'(3),
        WA_VCMP_LO = WADDR_W'(4),
        WA_VCMP_HI = WADDR_W'(5),
        WA_IRQ_CLR = WADDR_W'(6)
    } twaddr_e;

    typedef enum logic [RADDR_W-1:0] {
        RA_H_LO = RADDR_W'(0),
        RA_H_HI = RADDR_W'(1),
        RA_V_LO = RADDR_W'(2),
        RA_V_HI = RADDR_W'(3)
    } traddr_e;

    typedef struct packed {
        tmode_e mode;
        logic   ven;
        logic   hen;
    } tctrl_t;

    typedef struct packed {
        logic [CNT_W-1:0] v;
        logic [CNT_W-1:0] h;
    } tpos_t;

    function automatic logic [CNT_W-1:0] v_last(input logic fifty);
        return fifty ? V_LAST_50 : V_LAST_60;
    endfunction

    // One dot step in either mode.
    function automatic tpos_t advance(input tpos_t p, input tmode_e m, input logic fifty);
        tpos_t r;
        logic [LIN_W-1:0] lin;
        r = p;
        lin = '0;
        if (m == MODE_LINEAR) begin
            lin = {p.v, p.h} + LIN_W'(1);
            r.v = lin[LIN_W-1:CNT_W];
            r.h = lin[CNT_W-1:0];
        end else if (p.h >= H_LAST) begin
            r.h = '0;
            r.v = (p.v >= v_last(fifty)) ? '0 : p.v + CNT_ONE;
        end else begin
            r.h = p.h + CNT_ONE;
        end
        return r;
    endfunction

    function automatic logic is_hit(input tpos_t p, input tctrl_t c,
                                    input logic [CNT_W-1:0] hc, input logic [CNT_W-1:0] vc);
        return (c.hen || c.ven) && (!c.hen || p.h == hc) && (!c.ven || p.v == vc);
    endfunction
endpackage

// File: rtl/rtmr_regfile.sv
module rtmr_regfile
    import rtmr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [WADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    output tctrl_t             ctrl,
    output logic [CNT_W-1:0]   h_cmp,
    output logic [CNT_W-1:0]   v_cmp,
    output logic               restart,
    output logic               irq_clr
);
    always_comb begin
        restart = wr_en && (wr_addr == WA_RESTART);
        irq_clr = wr_en && (wr_addr == WA_IRQ_CLR) && wr_data[CLR_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= '0;
            h_cmp <= '0;
            v_cmp <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                WA_CTRL: begin
                    ctrl.mode <= tmode_e'(wr_data[MODE_BIT]);
                    ctrl.ven  <= wr_data[VEN_BIT];
                    ctrl.hen  <= wr_data[HEN_BIT];
                end
                WA_HCMP_LO: h_cmp[DATA_W-1:0]     <= wr_data;
                WA_HCMP_HI: h_cmp[CNT_W-1:DATA_W] <= wr_data[HI_W-1:0];
                WA_VCMP_LO: v_cmp[DATA_W-1:0]     <= wr_data;
                WA_VCMP_HI: v_cmp[CNT_W-1:DATA_W] <= wr_data[HI_W-1:0];
                default: ;
            endcase
        end
    end

    // R8: a high-byte write leaves the low compare bits alone
    a_r8_hi_keeps_lo: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_addr == WA_HCMP_HI |=> h_cmp[DATA_W-1:0] == $past(h_cmp[DATA_W-1:0]));
endmodule

// File: rtl/rtmr_counter.sv
module rtmr_counter
    import rtmr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   restart,
    input  tmode_e mode,
    input  logic   fifty,
    output tpos_t  pos,
    output tpos_t  pos_nxt
);
    always_comb begin
        if (restart)   pos_nxt = '0;
        else if (tick) pos_nxt = advance(pos, mode, fifty);
        else           pos_nxt = pos;
    end

    always_ff @(posedge clk) begin
        if (rst) pos <= '0;
        else     pos <= pos_nxt;
    end

    a_r2_restart_zero: assert property (@(posedge clk) disable iff (rst)
        restart |=> pos == '0);

    a_r3_h_wrap: assert property (@(posedge clk) disable iff (rst)
        tick && mode == MODE_RASTER && pos.h >= H_LAST |=> pos.h == '0);

    a_r4_v_wrap: assert property (@(posedge clk) disable iff (rst)
        tick && !restart && mode == MODE_RASTER && pos.h >= H_LAST && pos.v >= v_last(fifty)
        |=> pos.v == '0);

    a_r5_lin_carry: assert property (@(posedge clk) disable iff (rst)
        tick && !restart && mode == MODE_LINEAR && pos.h == '1
        |=> pos.h == '0 && pos.v == $past(pos.v) + CNT_ONE);

    a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !tick && !restart |=> $stable(pos));
endmodule

// File: rtl/rtmr_match.sv
module rtmr_match
    import rtmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             restart,
    input  tctrl_t           ctrl,
    input  logic [CNT_W-1:0] h_cmp,
    input  logic [CNT_W-1:0] v_cmp,
    input  tpos_t            pos_nxt,
    input  logic             irq_clr,
    output logic             irq
);
    logic hit;

    always_comb hit = tick && !restart && is_hit(pos_nxt, ctrl, h_cmp, v_cmp);

    always_ff @(posedge clk) begin
        if (rst)          irq <= 1'b0;
        else if (hit)     irq <= 1'b1;
        else if (irq_clr) irq <= 1'b0;
    end

    a_r6_no_tick_no_rise: assert property (@(posedge clk) disable iff (rst)
        !tick && !irq |=> !irq);

    a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        !ctrl.hen && !ctrl.ven && !irq |=> !irq);

    a_r7_clear_drops: assert property (@(posedge clk) disable iff (rst)
        irq_clr && !tick |=> !irq);

    a_r7_holds: assert property (@(posedge clk) disable iff (rst)
        irq && !irq_clr |=> irq);
endmodule

// File: rtl/rtmr_readback.sv
module rtmr_readback
    import rtmr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_en,
    input  logic [RADDR_W-1:0] rd_addr,
    input  tpos_t              pos,
    output logic [DATA_W-1:0]  rd_data
);
    tpos_t snap;
    logic  capture;

    always_comb capture = rd_en && (rd_addr == RA_H_LO);

    always_ff @(posedge clk) begin
        if (rst)          snap <= '0;
        else if (capture) snap <= pos;
    end

    always_comb begin
        case (rd_addr)
            RA_H_LO: rd_data = pos.h[DATA_W-1:0];
            RA_H_HI: rd_data = DATA_W'(snap.h[CNT_W-1:DATA_W]);
            RA_V_LO: rd_data = snap.v[DATA_W-1:0];
            RA_V_HI: rd_data = DATA_W'(snap.v[CNT_W-1:DATA_W]);
            default: rd_data = '0;
        endcase
    end

    a_r10_snap_hold: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(snap));

    a_r10_snap_load: assert property (@(posedge clk) disable iff (rst)
        capture |=> snap == $past(pos));
endmodule

// File: rtl/raster_timer.sv
module raster_timer
    import rtmr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               fifty_hz,
    input  logic               dot_en,
    input  logic               wr_en,
    input  logic [WADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               rd_en,
    input  logic [RADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    output logic               timer_irq
);
    tctrl_t           ctrl;
    logic [CNT_W-1:0] h_cmp;
    logic [CNT_W-1:0] v_cmp;
    logic             restart;
    logic             irq_clr;
    tpos_t            pos;
    tpos_t            pos_nxt;

    rtmr_regfile u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ctrl(ctrl), .h_cmp(h_cmp), .v_cmp(v_cmp), .restart(restart), .irq_clr(irq_clr)
    );

    rtmr_counter u_cnt (
        .clk(clk), .rst(rst), .tick(dot_en), .restart(restart), .mode(ctrl.mode),
        .fifty(fifty_hz), .pos(pos), .pos_nxt(pos_nxt)
    );

    rtmr_match u_match (
        .clk(clk), .rst(rst), .tick(dot_en), .restart(restart), .ctrl(ctrl),
        .h_cmp(h_cmp), .v_cmp(v_cmp), .pos_nxt(pos_nxt), .irq_clr(irq_clr), .irq(timer_irq)
    );

    rtmr_readback u_rd (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .pos(pos), .rd_data(rd_data)
    );

    // R1: flag is low in the first cycle after reset
    a_r1_reset_quiet: assert property (@(posedge clk) rst |=> !timer_irq);
endmodule

// File: tb/raster_timer_test.sv
module raster_timer_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fifty_hz = 1'b0;
    logic       dot_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       timer_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    raster_timer uut (
        .clk(clk), .rst(rst), .fifty_hz(fifty_hz), .dot_en(dot_en),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .timer_irq(timer_irq)
    );

    typedef struct packed {
        logic [7:0]  ctrl;
        logic        fifty;
        logic [8:0]  hcmp;
        logic [8:0]  vcmp;
        logic [17:0] n;
        logic [8:0]  eh;
        logic [8:0]  ev;
        logic        ei;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{8'h00, 1'b0, 9'd0,   9'd0, 18'd10,   9'd10,  9'd0, 1'b0},
        '{8'h00, 1'b0, 9'd0,   9'd0, 18'd341,  9'd0,   9'd1, 1'b0},
        '{8'h00, 1'b0, 9'd0,   9'd0, 18'd700,  9'd18,  9'd2, 1'b0},
        '{8'h01, 1'b0, 9'd5,   9'd0, 18'd5,    9'd5,   9'd0, 1'b1},
        '{8'h01, 1'b0, 9'd5,   9'd0, 18'd4,    9'd4,   9'd0, 1'b0},
        '{8'h03, 1'b0, 9'd3,   9'd1, 18'd343,  9'd2,   9'd1, 1'b0},
        '{8'h03, 1'b0, 9'd3,   9'd1, 18'd344,  9'd3,   9'd1, 1'b1},
        '{8'h02, 1'b0, 9'd0,   9'd1, 18'd340,  9'd340, 9'd0, 1'b0},
        '{8'h02, 1'b0, 9'd0,   9'd1, 18'd341,  9'd0,   9'd1, 1'b1},
        '{8'h80, 1'b0, 9'd0,   9'd0, 18'd600,  9'd88,  9'd1, 1'b0},
        '{8'h83, 1'b0, 9'd88,  9'd1, 18'd600,  9'd88,  9'd1, 1'b1},
        '{8'h83, 1'b0, 9'd88,  9'd2, 18'd600,  9'd88,  9'd1, 1'b0},
        '{8'h81, 1'b0, 9'd344, 9'd0, 18'd400,  9'd400, 9'd0, 1'b1},
        '{8'h81, 1'b0, 9'd344, 9'd0, 18'd343,  9'd343, 9'd0, 1'b0},
        '{8'h80, 1'b1, 9'd0,   9'd0, 18'd1100, 9'd76,  9'd2, 1'b0}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_byte(input logic [1:0] a, output logic [7:0] d);
        rd_en = 1'b1; rd_addr = a;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic read_pos(output logic [8:0] h, output logic [8:0] v);
        logic [7:0] lo, hi;
        rd_byte(2'd0, lo); rd_byte(2'd1, hi); h = {hi[0], lo};
        rd_byte(2'd2, lo); rd_byte(2'd3, hi); v = {hi[0], lo};
    endtask

    task automatic run(input int n);
        dot_en = 1'b1;
        repeat (n) @(negedge clk);
        dot_en = 1'b0;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (199000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual running expected finished");
        finish_up();
    end

    initial begin
        logic [8:0] h, v;
        logic [7:0] b;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        read_pos(h, v);
        check("R1 h after reset", h, 0);
        check("R1 v after reset", v, 0);
        check("R1 irq after reset", timer_irq, 0);

        // R3 R4 R5 R6 R8 R9: vector walk; high compare bytes carry junk above bit 0
        for (int i = 0; i < NV; i++) begin
            fifty_hz = VEC[i].fifty;
            wr(3'd0, VEC[i].ctrl);
            wr(3'd2, VEC[i].hcmp[7:0]);
            wr(3'd3, {7'b1010101, VEC[i].hcmp[8]});
            wr(3'd4, VEC[i].vcmp[7:0]);
            wr(3'd5, {7'b0110011, VEC[i].vcmp[8]});
            wr(3'd6, 8'h01);
            wr(3'd1, 8'h00);
            run(int'(VEC[i].n));
            read_pos(h, v);
            check($sformatf("R3_R5 vec%0d h", i), h, VEC[i].eh);
            check($sformatf("R4_R5 vec%0d v", i), v, VEC[i].ev);
            check($sformatf("R6_R8 vec%0d irq", i), timer_irq, VEC[i].ei);
        end

        // R2: restart ignores the data byte
        wr(3'd0, 8'h00);
        run(50);
        wr(3'd1, 8'h5A);
        read_pos(h, v);
        check("R2 restart h", h, 0);
        check("R2 restart v", v, 0);

        // R7: clear with bit 0 low has no effect, bit 0 high clears
        wr(3'd0, 8'h01); wr(3'd2, 8'd5); wr(3'd3, 8'h00);
        wr(3'd6, 8'h01); wr(3'd1, 8'h00);
        run(5);
        check("R7 irq set", timer_irq, 1);
        wr(3'd6, 8'hFE);
        check("R7 irq kept by bit0=0 clear", timer_irq, 1);
        wr(3'd6, 8'h01);
        check("R7 irq cleared", timer_irq, 0);
        run(3);
        check("R7 irq stays clear off-compare", timer_irq, 0);

        // R10: snapshot keeps the high byte consistent while counting
        wr(3'd0, 8'h00); wr(3'd1, 8'h00);
        dot_en = 1'b1;
        repeat (250) @(negedge clk);
        rd_byte(2'd0, b);
        check("R9 live low byte", b, 250);
        repeat (10) @(negedge clk);
        rd_byte(2'd1, b);
        check("R10 snapshot high byte", b, 0);
        dot_en = 1'b0;

        // R4: 50 Hz frame does not wrap at line 262
        fifty_hz = 1'b1;
        wr(3'd1, 8'h00);
        run(89342);
        read_pos(h, v);
        check("R4 50Hz h", h, 0);
        check("R4 50Hz v", v, 262);

        // R4: 60 Hz frame wraps after line 261
        fifty_hz = 1'b0;
        wr(3'd1, 8'h00);
        run(89341);
        read_pos(h, v);
        check("R4 60Hz last h", h, 340);
        check("R4 60Hz last v", v, 261);
        run(1);
        read_pos(h, v);
        check("R4 60Hz wrap h", h, 0);
        check("R4 60Hz wrap v", v, 0);

        finish_up();
    end
endmodule